// File: doc/BRIEF.md
# Serial Test Pattern Receiver with Sync and Error Counting

The block checks a received serial test stream against a pattern that it regenerates locally from a programmable shift-register polynomial. The polynomial uses the same length and tap settings as the transmitting pattern source. On each receive-clock edge where the disable input is low, one data bit is taken in. The receiver first hunts for alignment. During the hunt it loads the incoming bits into its own history register. Once it sees a run of error-free bits, it declares sync. From then on it runs on its own regenerated pattern, so that a received error is not copied into the reference.

While it holds sync, two saturating counters run alongside each other. One counts the checked bits and the other counts the bits that did not match. A latch strobe copies both counters into output registers and restarts them. A status word reports the following:
- sync
- loss of signal
- bit error seen
- overflow of each counter

Each status bit can be enabled onto a single interrupt output through a mask input.

Top module: `bert_rx_check`

## Requirements
- R1: After reset or resync the receiver hunts. The expected bit is hist[len_i] XOR hist[tap_i], where hist[0] is the most recently shifted bit. While hunting, the received bit is shifted in. Sync (status_o[0]) is set after 32 consecutive enabled bits that match, counted from the start of the hunt.
- R2: While in sync, the regenerated expected bit is shifted into the history. Every enabled bit increments the live bit counter.
- R3: While in sync, every enabled bit that differs from the expected bit increments the live error counter and sets the sticky error-seen flag status_o[2].
- R4: A bit received while rx_dis_i is high is ignored: it changes neither the history, the sync search, the loss-of-signal detector nor either counter.
- R5: A latch_i pulse copies both live counters into bit_cnt_o and err_cnt_o. It clears both live counters and clears status_o[4:2].
- R6: Each live counter saturates at all ones. An increment requested at all ones sets its overflow flag: status_o[3] for the bit counter and status_o[4] for the error counter.
- R7: With sync_en_i high, sync is dropped when 6 errors fall within one 64-bit block. Blocks are counted from the moment of lock. The receiver then hunts again on its own.
- R8: With sync_en_i low, errors never drop sync.
- R9: A resync_i pulse clears sync on the next edge and restarts the hunt. The history is kept, so a clean stream regains sync after exactly 32 further bits.
- R10: Loss of signal (status_o[1]) is set on the 32nd consecutive enabled zero. It is cleared by the first enabled one.
- R11: The status bit order is sync[0], los[1], err_seen[2], bit_ovf[3], err_ovf[4]. irq_o is high whenever any status bit with its irq_mask_i bit set is high.
- R12: After reset, the status, both output counts and irq_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_dis_i | input | 1 | Ignore the bit on this edge |
| rx_data_i | input | 1 | Serial received data |
| len_i | input | SEL_W | Polynomial length minus one (history index) |
| tap_i | input | SEL_W | Feedback tap index |
| resync_i | input | 1 | Force reacquisition |
| sync_en_i | input | 1 | Allow automatic loss of sync on errors |
| latch_i | input | 1 | Snapshot and clear the counters |
| irq_mask_i | input | 5 | Per-status interrupt enable |
| bit_cnt_o | output | CNT_W | Latched bit count |
| err_cnt_o | output | CNT_W | Latched error count |
| status_o | output | 5 | Status flags |
| irq_o | output | 1 | Interrupt |

## Verification
The hardest state to reach is counter overflow. A 32-bit count cannot be reached in a short run, so the bench builds the block with 8-bit counters. It then feeds a long stretch of inverted pattern while automatic resync is off. This saturates both counters at once without losing lock. Loss of sync also needs care, because the 64-bit blocks are aligned to the lock instant, which cannot be seen from the ports. The bench therefore injects 12 consecutive errors, so that at least 6 of them must fall in one block.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;
  localparam int unsigned STATUS_W = 5;

  typedef struct packed {
    logic err_ovf;
    logic bit_ovf;
    logic err_seen;
    logic los;
    logic sync;
  } status_t;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } sync_state_e;
endpackage

// File: rtl/bert_rx_pattern.sv
module bert_rx_pattern #(
  parameter int unsigned HIST_W = 32,
  localparam int unsigned SEL_W = $clog2(HIST_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             seed_i,
  input  logic             rx_data_i,
  input  logic [SEL_W-1:0] len_i,
  input  logic [SEL_W-1:0] tap_i,
  output logic             exp_o
);
  logic [HIST_W-1:0] hist_q;
  logic              in_bit;

  assign exp_o  = hist_q[len_i] ^ hist_q[tap_i];
  // hunting: load line data; locked: free-run on regenerated bit
  assign in_bit = seed_i ? rx_data_i : exp_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else if (adv_i) hist_q <= {hist_q[HIST_W-2:0], in_bit};
  end
endmodule

// File: rtl/bert_rx_sync.sv
module bert_rx_sync
  import bert_rx_pkg::*;
#(
  parameter int unsigned SYNC_RUN  = 32,
  parameter int unsigned ERR_WIN   = 64,
  parameter int unsigned ERR_LIMIT = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic mism_i,
  input  logic resync_i,
  input  logic sync_en_i,
  output logic locked_o
);
  localparam int unsigned RUN_W = $clog2(SYNC_RUN + 1);
  localparam int unsigned WIN_W = $clog2(ERR_WIN);
  localparam int unsigned LIM_W = $clog2(ERR_LIMIT + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(SYNC_RUN - 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(ERR_WIN - 1);
  localparam logic [LIM_W-1:0] LIM_LAST = LIM_W'(ERR_LIMIT - 1);

  sync_state_e      state_q;
  logic [RUN_W-1:0] run_q;
  logic [WIN_W-1:0] win_q;
  logic [LIM_W-1:0] werr_q;
  logic             drop;

  assign drop     = mism_i && (werr_q == LIM_LAST) && sync_en_i;
  assign locked_o = (state_q == ST_LOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      run_q   <= '0;
      win_q   <= '0;
      werr_q  <= '0;
    end else if (resync_i) begin
      state_q <= ST_HUNT;
      run_q   <= '0;
      win_q   <= '0;
      werr_q  <= '0;
    end else if (adv_i) begin
      unique case (state_q)
        ST_HUNT: begin
          if (mism_i) run_q <= '0;
          else if (run_q == RUN_LAST) begin
            state_q <= ST_LOCK;
            run_q   <= '0;
            win_q   <= '0;
            werr_q  <= '0;
          end else run_q <= run_q + RUN_W'(1);
        end
        ST_LOCK: begin
          if (drop) begin
            state_q <= ST_HUNT;
            run_q   <= '0;
          end
          if (win_q == WIN_LAST) begin
            win_q  <= '0;
            werr_q <= '0;
          end else begin
            win_q <= win_q + WIN_W'(1);
            if (mism_i && werr_q != LIM_LAST) werr_q <= werr_q + LIM_W'(1);
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/bert_rx_satcnt.sv
module bert_rx_satcnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         latch_i,
  output logic [W-1:0] live_o,
  output logic [W-1:0] snap_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q, snap_q;
  logic         ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      snap_q <= '0;
      ovf_q  <= 1'b0;
    end else if (latch_i) begin
      snap_q <= cnt_q;
      cnt_q  <= inc_i ? ONE : '0;  // no bit lost across the latch
      ovf_q  <= 1'b0;
    end else if (inc_i) begin
      if (cnt_q == TOP) ovf_q <= 1'b1;
      else cnt_q <= cnt_q + ONE;
    end
  end

  assign live_o = cnt_q;
  assign snap_o = snap_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/bert_rx_los.sv
module bert_rx_los #(
  parameter int unsigned ZERO_RUN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic rx_data_i,
  output logic los_o
);
  localparam int unsigned ZW = $clog2(ZERO_RUN);
  localparam logic [ZW-1:0] Z_LAST = ZW'(ZERO_RUN - 1);

  logic [ZW-1:0] zcnt_q;
  logic          los_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zcnt_q <= '0;
      los_q  <= 1'b0;
    end else if (adv_i) begin
      if (rx_data_i) begin
        zcnt_q <= '0;
        los_q  <= 1'b0;
      end else if (zcnt_q == Z_LAST) los_q <= 1'b1;
      else zcnt_q <= zcnt_q + ZW'(1);
    end
  end

  assign los_o = los_q;
endmodule

// File: rtl/bert_rx_check.sv
module bert_rx_check
  import bert_rx_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned HIST_W    = 32,
  parameter int unsigned SYNC_RUN  = 32,
  parameter int unsigned ERR_WIN   = 64,
  parameter int unsigned ERR_LIMIT = 6,
  parameter int unsigned ZERO_RUN  = 32,
  localparam int unsigned SEL_W    = $clog2(HIST_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_dis_i,
  input  logic                rx_data_i,
  input  logic [SEL_W-1:0]    len_i,
  input  logic [SEL_W-1:0]    tap_i,
  input  logic                resync_i,
  input  logic                sync_en_i,
  input  logic                latch_i,
  input  logic [STATUS_W-1:0] irq_mask_i,
  output logic [CNT_W-1:0]    bit_cnt_o,
  output logic [CNT_W-1:0]    err_cnt_o,
  output logic [STATUS_W-1:0] status_o,
  output logic                irq_o
);
  localparam int unsigned N_CNT = 2;

  logic adv, exp_bit, mism, locked, los, err_seen_q;
  logic [N_CNT-1:0]             inc_vec, ovf_vec;
  logic [N_CNT-1:0][CNT_W-1:0]  live_vec, snap_vec;
  logic [CNT_W-1:0]             bit_live, err_live;
  status_t                      st;

  assign adv  = !rx_dis_i;
  assign mism = rx_data_i ^ exp_bit;

  bert_rx_pattern #(.HIST_W(HIST_W)) u_pattern (
    .clk_i, .rst_ni,
    .adv_i     (adv),
    .seed_i    (!locked),
    .rx_data_i,
    .len_i, .tap_i,
    .exp_o     (exp_bit)
  );

  bert_rx_sync #(
    .SYNC_RUN(SYNC_RUN), .ERR_WIN(ERR_WIN), .ERR_LIMIT(ERR_LIMIT)
  ) u_sync (
    .clk_i, .rst_ni,
    .adv_i    (adv),
    .mism_i   (mism),
    .resync_i,
    .sync_en_i,
    .locked_o (locked)
  );

  bert_rx_los #(.ZERO_RUN(ZERO_RUN)) u_los (
    .clk_i, .rst_ni,
    .adv_i     (adv),
    .rx_data_i,
    .los_o     (los)
  );

  // index 0: checked bits, index 1: errored bits
  assign inc_vec[0] = adv && locked;
  assign inc_vec[1] = adv && locked && mism;

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    bert_rx_satcnt #(.W(CNT_W)) u_cnt (
      .clk_i, .rst_ni,
      .inc_i   (inc_vec[g]),
      .latch_i,
      .live_o  (live_vec[g]),
      .snap_o  (snap_vec[g]),
      .ovf_o   (ovf_vec[g])
    );
  end

  assign bit_live  = live_vec[0];
  assign err_live  = live_vec[1];
  assign bit_cnt_o = snap_vec[0];
  assign err_cnt_o = snap_vec[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_seen_q <= 1'b0;
    else if (latch_i) err_seen_q <= 1'b0;
    else if (inc_vec[1]) err_seen_q <= 1'b1;
  end

  always_comb begin
    st          = '0;
    st.sync     = locked;
    st.los      = los;
    st.err_seen = err_seen_q;
    st.bit_ovf  = ovf_vec[0];
    st.err_ovf  = ovf_vec[1];
  end

  assign status_o = st;
  assign irq_o    = |(status_o & irq_mask_i);
endmodule

// File: rtl/bert_rx_check_sva.sv
module bert_rx_check_sva #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_dis_i,
  input logic             rx_data_i,
  input logic             resync_i,
  input logic             latch_i,
  input logic [4:0]       status_o,
  input logic [CNT_W-1:0] bit_live_i,
  input logic [CNT_W-1:0] err_live_i
);
  AST_SYNC_ON_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> $past(!rx_dis_i)); // R1

  AST_ERR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_live_i <= bit_live_i); // R3

  AST_DIS_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dis_i && !latch_i |=> $stable(bit_live_i) && $stable(err_live_i)); // R4

  AST_LATCH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i && rx_dis_i |=> bit_live_i == '0 && err_live_i == '0); // R5

  AST_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_live_i == {CNT_W{1'b1}} && !latch_i |=> bit_live_i == {CNT_W{1'b1}}); // R6

  AST_RESYNC_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> !status_o[0]); // R9

  AST_LOS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_dis_i && rx_data_i |=> !status_o[1]); // R10
endmodule

bind bert_rx_check bert_rx_check_sva #(.CNT_W(CNT_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_dis_i   (rx_dis_i),
  .rx_data_i  (rx_data_i),
  .resync_i   (resync_i),
  .latch_i    (latch_i),
  .status_o   (status_o),
  .bit_live_i (bit_live),
  .err_live_i (err_live)
);

// File: tb/bert_rx_check_bench.sv
module bert_rx_check_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int LEN = 6;  // x^7 + x^6 + 1
  localparam int TAP = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_dis = 1'b0, rx_data = 1'b0, resync = 1'b0, sync_en = 1'b1, latch = 1'b0;
  logic [4:0] len = 5'(LEN), tap = 5'(TAP), mask = 5'h1f;
  logic [CNT_W-1:0] bit_cnt, err_cnt;
  logic [4:0] status;
  logic irq;

  int tests = 0, fails = 0;
  logic [31:0] h = 32'h0000_005a;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bert_rx_check #(.CNT_W(CNT_W)) u_bert_rx_check (
    .clk_i(clk), .rst_ni(rst_n), .rx_dis_i(rx_dis), .rx_data_i(rx_data),
    .len_i(len), .tap_i(tap), .resync_i(resync), .sync_en_i(sync_en),
    .latch_i(latch), .irq_mask_i(mask), .bit_cnt_o(bit_cnt),
    .err_cnt_o(err_cnt), .status_o(status), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(input logic d, input logic dis);
    rx_data = d;
    rx_dis  = dis;
    @(negedge clk);
  endtask

  task automatic prbs_bit(input logic flip);
    logic nb;
    nb = h[LEN] ^ h[TAP];
    step(nb ^ flip, 1'b0);
    h = {h[30:0], nb};
  endtask

  task automatic do_latch();
    latch = 1'b1;
    step(1'b0, 1'b1);
    latch = 1'b0;
  endtask

  task automatic t_reset();
    check(status == 5'd0, "R12 status", status, 0);
    check(bit_cnt == 0 && err_cnt == 0, "R12 counts", bit_cnt, 0);
    check(irq == 1'b0, "R12 irq", irq, 0);
  endtask

  task automatic t_acquire();
    int n = 0;
    for (int i = 1; i <= 60; i++) begin
      prbs_bit(1'b0);
      if (status[0] && n == 0) n = i;
    end
    check(n >= 32 && n <= 39, "R1 sync bit index", n, 32);
  endtask

  task automatic t_count();
    do_latch();
    for (int i = 0; i < 100; i++) prbs_bit(i == 10 || i == 40 || i == 70);
    check(status[2] == 1'b1, "R3 err_seen set", status[2], 1);
    check(status[0] == 1'b1, "R2 sync kept", status[0], 1);
    do_latch();
    check(bit_cnt == 8'd100, "R2 bit count", bit_cnt, 100);
    check(err_cnt == 8'd3, "R3 err count", err_cnt, 3);
    check(status[2] == 1'b0, "R5 err_seen cleared", status[2], 0);
  endtask

  task automatic t_disable();
    for (int i = 0; i < 20; i++) step(1'(i % 3 == 0), 1'b1);
    for (int i = 0; i < 10; i++) prbs_bit(1'b0);
    do_latch();
    check(bit_cnt == 8'd10, "R4 bit count", bit_cnt, 10);
    check(err_cnt == 8'd0, "R4 err count", err_cnt, 0);
    check(status[0] == 1'b1, "R4 sync kept", status[0], 1);
  endtask

  task automatic t_irq();
    mask = 5'b00001; #1;
    check(irq == 1'b1, "R11 irq on sync", irq, 1);
    mask = 5'b00100; #1;
    check(irq == 1'b0, "R11 irq masked", irq, 0);
    mask = 5'b00000;
  endtask

  task automatic t_saturate();
    do_latch();
    sync_en = 1'b0;
    for (int i = 0; i < 300; i++) prbs_bit(1'b1);
    check(status[4:3] == 2'b11, "R6 ovf flags", status[4:3], 3);
    do_latch();
    check(bit_cnt == 8'd255, "R6 bit sat", bit_cnt, 255);
    check(err_cnt == 8'd255, "R6 err sat", err_cnt, 255);
    check(status[4:3] == 2'b00, "R5 ovf cleared", status[4:3], 0);
  endtask

  task automatic t_hold();
    sync_en = 1'b0;
    for (int i = 0; i < 12; i++) prbs_bit(1'b1);
    check(status[0] == 1'b1, "R8 sync held", status[0], 1);
    sync_en = 1'b1;
    for (int i = 0; i < 70; i++) prbs_bit(1'b0);
  endtask

  task automatic t_loss();
    int n = 0;
    sync_en = 1'b1;
    for (int i = 0; i < 12; i++) prbs_bit(1'b1);
    check(status[0] == 1'b0, "R7 sync lost", status[0], 0);
    for (int i = 1; i <= 45; i++) begin
      prbs_bit(1'b0);
      if (status[0] && n == 0) n = i;
    end
    check(n >= 32 && n <= 39, "R7 auto reacquire", n, 32);
  endtask

  task automatic t_resync();
    int n = 0;
    resync = 1'b1;
    prbs_bit(1'b0);
    resync = 1'b0;
    check(status[0] == 1'b0, "R9 sync cleared", status[0], 0);
    for (int i = 1; i <= 40; i++) begin
      prbs_bit(1'b0);
      if (status[0] && n == 0) n = i;
    end
    check(n == 32, "R9 reacquire count", n, 32);
  endtask

  task automatic t_los();
    for (int i = 0; i < 31; i++) step(1'b0, 1'b0);
    check(status[1] == 1'b0, "R10 los after 31", status[1], 0);
    step(1'b0, 1'b1);
    check(status[1] == 1'b0, "R10 los ignores disabled", status[1], 0);
    step(1'b0, 1'b0);
    check(status[1] == 1'b1, "R10 los after 32", status[1], 1);
    step(1'b1, 1'b0);
    check(status[1] == 1'b0, "R10 los cleared", status[1], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_acquire();
    t_count();
    t_disable();
    t_irq();
    t_saturate();
    t_hold();
    t_loss();
    t_resync();
    t_los();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule